// File: doc/BRIEF.md
# Vector Addition Engine

This block sums two vectors held in two separate synchronous RAMs and writes the result vector into a third RAM. A controlling module requests a run by raising `start` for one cycle while presenting the element count. The engine then walks an index from zero upwards. For each index it drives one shared read address to both source memories. In the next cycle it takes the two read words, adds them and writes the sum to the result memory at the same index.

The source memories return data one cycle after they see an address. Each element therefore takes two cycles: one that presents the address and one that uses the data and writes the result. When the last element has been written, the engine pulses `done` for one cycle and goes back to idle. The controller waits for that pulse before it issues another request.

Control and datapath are separate modules. The controller has a clocked state register and a purely combinational next-state and strobe process. The index counter is only as wide as the RAM address.

Top module: `vector_adder`

## Requirements
- R1: `rstN` is an active-low asynchronous reset. While it is low, `done` and `zWe` are 0 at once, without waiting for a clock edge, and the engine is idle.
- R2: A run starts when `start` is high at a rising edge while the engine is idle. In the cycle after that edge `rdAddr` carries index 0. Every write of index i happens in the cycle directly after the cycle in which `rdAddr` carried i, because read data is valid one cycle after the address.
- R3: For a count n > 0, the engine writes exactly n words, at `zAddr` = 0, 1, ..., n-1 in ascending order. Writes come in every second cycle, and the word written at index i is the sum of the two source words at index i. No other address of the result memory is written.
- R4: `done` is high for exactly one cycle. That cycle directly follows the cycle of the last write, and the engine is idle again after it.
- R5: A request with count 0 makes no write. `done` is pulsed in the cycle after the edge that accepted the request.
- R6: `start` is ignored in every cycle from acceptance up to and including the `done` cycle. A repeated request with another count during a run changes neither the number of writes nor their timing.
- R7: The sum is truncated to DATA_W bits, so a carry out of the top bit is dropped and the result wraps.
- R8: A count equal to the full memory depth, 2**ADDR_W, processes every address from 0 to 2**ADDR_W-1, even though the index register is only ADDR_W bits wide.
- R9: `zWe` and `done` are never high in the same cycle, and neither is high while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Run request, sampled only when idle |
| count | input | ADDR_W+1 | Number of elements, 0 to 2**ADDR_W |
| rdAddr | output | ADDR_W | Shared read address for both source RAMs |
| xData | input | DATA_W | Read data from the first source RAM, one cycle after the address |
| yData | input | DATA_W | Read data from the second source RAM, one cycle after the address |
| zWe | output | 1 | Write enable of the result RAM |
| zAddr | output | ADDR_W | Write address of the result RAM |
| zData | output | DATA_W | Sum word to be written |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: a new `start` request and the engine's own activity, either a write cycle or the `done` cycle. In one run the bench raises `start` with a different count on every cycle of the run, including the `done` cycle. The cycle model then has to find the writes, their timing and the single `done` pulse unchanged, and the engine has to return to idle rather than start again. A second coincidence comes from source words that overflow in the adder during a normal write cycle. Those are judged against sums the bench computes modulo 2**DATA_W.

// File: rtl/vector_adder_pkg.sv
package vector_adder_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ISSUE   = 2'd1,
    ST_CAPTURE = 2'd2,
    ST_FINISH  = 2'd3
  } vaState_e;

  typedef struct packed {
    logic loadCount;
    logic clearIdx;
    logic incIdx;
    logic writeZ;
    logic donePulse;
  } vaCtrl_t;

endpackage

// File: rtl/vector_adder_ctrl.sv
module vector_adder_ctrl
  import vector_adder_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    countZero,
  input  logic    lastElem,
  output vaCtrl_t strobes,
  output logic    busy
);

  vaState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD  = stateQ;
    strobes = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strobes.loadCount = 1'b1;
          strobes.clearIdx  = 1'b1;
          stateD = countZero ? ST_FINISH : ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        // address is on the bus this cycle, data arrives next cycle
        stateD = ST_CAPTURE;
      end
      ST_CAPTURE: begin
        strobes.writeZ = 1'b1;
        if (lastElem) begin
          stateD = ST_FINISH;
        end else begin
          strobes.incIdx = 1'b1;
          stateD = ST_ISSUE;
        end
      end
      ST_FINISH: begin
        strobes.donePulse = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign busy = (stateQ != ST_IDLE);

endmodule

// File: rtl/vector_adder_dp.sv
module vector_adder_dp
  import vector_adder_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  vaCtrl_t           strobes,
  input  logic [ADDR_W:0]   count,
  input  logic [DATA_W-1:0] xData,
  input  logic [DATA_W-1:0] yData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              zWe,
  output logic [ADDR_W-1:0] zAddr,
  output logic [DATA_W-1:0] zData,
  output logic              done,
  output logic              countZero,
  output logic              lastElem
);

  localparam int CNT_W = ADDR_W + 1;

  logic [ADDR_W-1:0] idxQ;
  logic [CNT_W-1:0]  countQ;
  logic [CNT_W-1:0]  idxNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ   <= '0;
      countQ <= '0;
    end else begin
      if (strobes.loadCount) countQ <= count;
      if (strobes.clearIdx)    idxQ <= '0;
      else if (strobes.incIdx) idxQ <= idxQ + 1'b1;
    end
  end

  // compare one bit wider than the index so that a full-depth count is exact
  assign idxNext   = {1'b0, idxQ} + CNT_W'(1);
  assign lastElem  = (idxNext == countQ);
  assign countZero = (count == '0);

  assign rdAddr = idxQ;
  assign zAddr  = idxQ;
  assign zData  = xData + yData;
  assign zWe    = strobes.writeZ;
  assign done   = strobes.donePulse;

endmodule

// File: rtl/vector_adder.sv
module vector_adder
  import vector_adder_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W:0]   count,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] xData,
  input  logic [DATA_W-1:0] yData,
  output logic              zWe,
  output logic [ADDR_W-1:0] zAddr,
  output logic [DATA_W-1:0] zData,
  output logic              done
);

  vaCtrl_t strobes;
  logic    countZero;
  logic    lastElem;
  logic    engBusy;

  vector_adder_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .countZero (countZero),
    .lastElem  (lastElem),
    .strobes   (strobes),
    .busy      (engBusy)
  );

  vector_adder_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .count     (count),
    .xData     (xData),
    .yData     (yData),
    .rdAddr    (rdAddr),
    .zWe       (zWe),
    .zAddr     (zAddr),
    .zData     (zData),
    .done      (done),
    .countZero (countZero),
    .lastElem  (lastElem)
  );

endmodule

// File: rtl/vector_adder_chk.sv
module vector_adder_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [ADDR_W:0]   count,
  input logic              busy,
  input logic              done,
  input logic              zWe,
  input logic [ADDR_W-1:0] zAddr,
  input logic [ADDR_W-1:0] rdAddr
);

  // R4: the completion pulse lasts one cycle and leaves the engine idle
  p_done_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R5: an empty request completes next cycle without a write
  p_zero_count_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && count == '0) |=> (done && !zWe));

  // R2: a write uses the index that was on the read address one cycle before
  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    zWe |-> (zAddr == $past(rdAddr)));

  // R3: writes never come in back-to-back cycles
  p_write_spacing_r3: assert property (@(posedge clk) disable iff (!rstN)
    zWe |=> !zWe);

  // R9: no write together with done, nothing at all while idle
  p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy |-> (!zWe && !done)) and (zWe |-> !done));

  // R6: a request in a non-idle cycle does not lead to a fresh acceptance
  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && start) |=> busy);

endmodule

bind vector_adder vector_adder_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) uChk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .count  (count),
  .busy   (engBusy),
  .done   (done),
  .zWe    (zWe),
  .zAddr  (zAddr),
  .rdAddr (rdAddr)
);

// File: tb/sim_vector_adder.sv
`timescale 1ns/1ps
module sim_vector_adder;

  localparam int AW    = 5;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [AW:0]   count = '0;
  logic [AW-1:0] rdAddr;
  logic [DW-1:0] xData, yData;
  logic          zWe;
  logic [AW-1:0] zAddr;
  logic [DW-1:0] zData;
  logic          done;

  logic [DW-1:0] xMem [DEPTH];
  logic [DW-1:0] yMem [DEPTH];
  logic [DW-1:0] zMem [DEPTH];
  logic [DW-1:0] refZ [DEPTH];

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  // behavioural cycle model: 0 idle, 1 address, 2 write, 3 done
  int mState = 0;
  int mIdx   = 0;
  int mN     = 0;

  always #2.5 clk = ~clk;

  vector_adder #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .count(count),
    .rdAddr(rdAddr), .xData(xData), .yData(yData),
    .zWe(zWe), .zAddr(zAddr), .zData(zData), .done(done)
  );

  // source RAMs with one cycle read latency, result RAM
  always @(posedge clk) begin
    xData <= xMem[rdAddr];
    yData <= yMem[rdAddr];
    if (zWe) zMem[zAddr] <= zData;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0;
      mIdx   = 0;
    end else begin
      if (mState == 0) begin
        if (start) begin
          mN = int'(count);
          mIdx = 0;
          mState = (mN == 0) ? 3 : 1;
        end
      end else if (mState == 1) begin
        mState = 2;
      end else if (mState == 2) begin
        refZ[mIdx] = DW'(int'(xMem[mIdx]) + int'(yMem[mIdx]));
        if (mIdx == mN - 1) mState = 3;
        else begin mIdx++; mState = 1; end
      end else begin
        mState = 0;
      end
    end
  end

  // per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (rstN) begin
      chk(zWe == (mState == 2), "R3 write strobe", int'(zWe), int'(mState == 2));
      chk(done == (mState == 3), "R4 done pulse", int'(done), int'(mState == 3));
      if (mState == 1)
        chk(int'(rdAddr) == mIdx, "R2 read address", int'(rdAddr), mIdx);
      if (mState == 2 && zWe) begin
        chk(int'(zAddr) == mIdx, "R3 write index", int'(zAddr), mIdx);
        chk(zData == DW'(int'(xMem[mIdx]) + int'(yMem[mIdx])),
            "R7 truncated sum", int'(zData),
            int'(DW'(int'(xMem[mIdx]) + int'(yMem[mIdx]))));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
      report();
    end
  end

  task automatic clearZ();
    for (int i = 0; i < DEPTH; i++) begin
      zMem[i] = 8'h5A;
      refZ[i] = 8'h5A;
    end
  endtask

  task automatic checkZ(input string req);
    for (int i = 0; i < DEPTH; i++)
      chk(zMem[i] == refZ[i], req, int'(zMem[i]), int'(refZ[i]));
  endtask

  // noisy: keep start high with another count on every cycle of the run
  task automatic runVec(input int n, input bit noisy);
    @(negedge clk);
    start = 1'b1;
    count = (AW+1)'(n);
    for (int k = 0; k < 4 * DEPTH + 8; k++) begin
      @(negedge clk);
      if (mState == 0) break;
      start = noisy;
      count = (AW+1)'(3);
    end
    start = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      xMem[i] = DW'(i * 37 + 5);
      yMem[i] = DW'(i * 11 + 3);
    end
    clearZ();
    #1;
    chk(done == 1'b0, "R1 done in reset", int'(done), 0);
    chk(zWe == 1'b0, "R1 write in reset", int'(zWe), 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R2 R3 R4: plain run
    runVec(8, 1'b0);
    checkZ("R3 result memory n=8");

    // R5: empty request, memory untouched
    clearZ();
    runVec(0, 1'b0);
    checkZ("R5 no write for n=0");

    // R7: wrapping sums
    for (int i = 0; i < DEPTH; i++) begin
      xMem[i] = DW'(200 + i);
      yMem[i] = DW'(100 + 3 * i);
    end
    clearZ();
    runVec(12, 1'b0);
    checkZ("R7 wrapped results");

    // R8: full depth
    clearZ();
    runVec(DEPTH, 1'b0);
    checkZ("R8 full depth");

    // R6: requests during the run and in the done cycle are ignored
    clearZ();
    runVec(7, 1'b1);
    checkZ("R6 run length unchanged");
    repeat (3) @(negedge clk);
    chk(zWe == 1'b0 && done == 1'b0, "R6 no restart", int'(zWe | done), 0);

    // R1: asynchronous reset in the middle of a run
    clearZ();
    @(negedge clk);
    start = 1'b1;
    count = (AW+1)'(10);
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    #1 rstN = 1'b0;
    #0.5;
    chk(zWe == 1'b0, "R1 async write clear", int'(zWe), 0);
    chk(done == 1'b0, "R1 async done clear", int'(done), 0);
    @(negedge clk);
    rstN = 1'b1;
    clearZ();
    runVec(5, 1'b0);
    checkZ("R1 recovery after reset");

    // R9: idle stays quiet
    repeat (4) begin
      @(negedge clk);
      chk(!zWe && !done, "R9 idle quiet", int'(zWe | done), 0);
    end
    report();
  end

endmodule